// File: doc/BRIEF.md
# Control-Byte Framed Serial Command Slave

This block is a serial slave that sits behind a four-wire style link: a master lowers an active-low enable, clocks bits in on a shared data line, and raises enable to close the frame. The first byte of every frame is a control byte. It decides what the rest of the frame carries. One value opens a command write of fixed length. Four values open a read: a single status byte or a full sixteen-byte response, sent either on the shared data line or on a separate auxiliary output pin. Any other control value leaves the slave idle until the frame ends.

All serial inputs are sampled by a fast system clock, and the edges of the serial clock are detected in that domain. A command write only produces a one-cycle command-ready strobe, with the eight bytes presented in parallel, when exactly eight bytes arrived before enable rose. Short, long or aborted frames are discarded. The response bytes come from a parallel input that a separate producer keeps up to date. The slave works only when both strap inputs are high while reset is released.

Top module: `ctlbyte_spi_slave`

## Requirements
- R1: If strap_a and strap_b are not both 1 during the last reset cycle, the slave accepts no frame: sdo_oe, aux_oe and cmd_valid stay 0 whatever the serial inputs do.
- R2: Control byte 0x48 followed by exactly eight bytes (bits taken MSB first on sclk rising edges) raises cmd_valid for exactly one system clock, in the cycle after sen_n is first seen high, with byte k of the frame in cmd_data[8k+7:8k].
- R3: Control byte 0x80 drives the status byte rsp_in[7:0] MSB first on sdo, each bit changing only after an sclk falling edge; further bits of the frame read 0, and aux_oe stays 0.
- R4: Control byte 0xC0 drives sixteen bytes on sdo, byte k taken from rsp_in[8k+7:8k], MSB first, starting with the status byte.
- R5: Control byte 0xA0 drives the status byte on aux_do with aux_oe high, while sdo_oe stays 0 for the whole frame.
- R6: Control byte 0xE0 drives the sixteen response bytes on aux_do in the same order as R4, with sdo_oe held at 0.
- R7: A write frame closed after fewer than eight data bytes, including one cut in the middle of a byte, gives no cmd_valid and leaves cmd_data unchanged.
- R8: A write frame carrying more than eight data bytes gives no cmd_valid and leaves cmd_data unchanged.
- R9: A control byte other than 0x48, 0x80, 0xC0, 0xA0 or 0xE0 enables neither output and raises no cmd_valid for the rest of the frame; the next frame is decoded normally.
- R10: sdo_oe and aux_oe are never high together, and both are 0 at the first system clock edge after sen_n goes high.
- R11: After reset, sdo_oe, aux_oe and cmd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_a | input | 1 | Mode strap, sampled while reset is low |
| strap_b | input | 1 | Mode strap, sampled while reset is low |
| sclk | input | 1 | Serial clock from the master |
| sen_n | input | 1 | Active-low frame enable |
| sdi | input | 1 | Serial data from the master (shared line input side) |
| sdo | output | 1 | Read data on the shared line |
| sdo_oe | output | 1 | Drive enable of the shared line |
| aux_do | output | 1 | Read data on the auxiliary pin |
| aux_oe | output | 1 | Drive enable of the auxiliary pin |
| rsp_in | input | 8*RSP_BYTES | Response bytes, byte 0 is status |
| cmd_data | output | 8*CMD_BYTES | Last accepted command, byte 0 is the opcode |
| cmd_valid | output | 1 | One-cycle command-ready strobe |

## Verification
The hardest situation to reach is a write frame that ends at the wrong length, because from the ports it looks exactly like a good frame until enable rises. The stimulus sends the write control byte followed by five bytes, by three and a half bytes, and by nine bytes, each after a good write has loaded a known command, so that both the missing strobe and the unchanged command output are visible. An illegal control byte followed by clocked bytes, and a legal frame right after it, shows that the idle state neither drives nor lingers.

// File: rtl/ctlbyte_spi_slave.sv
module ctlbyte_spi_slave #(
  parameter int CMD_BYTES = 8,
  parameter int RSP_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strap_a,
  input  logic                   strap_b,
  input  logic                   sclk,
  input  logic                   sen_n,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic                   aux_do,
  output logic                   aux_oe,
  input  logic [8*RSP_BYTES-1:0] rsp_in,
  output logic [8*CMD_BYTES-1:0] cmd_data,
  output logic                   cmd_valid
);
  localparam int CMD_BITS = 8 * CMD_BYTES;
  localparam int RSP_BITS = 8 * RSP_BYTES;
  localparam int CW       = $clog2(CMD_BITS + 2);

  localparam logic [7:0] OP_WRITE  = 8'h48;
  localparam logic [7:0] OP_ST_DIO = 8'h80;
  localparam logic [7:0] OP_RS_DIO = 8'hC0;
  localparam logic [7:0] OP_ST_AUX = 8'hA0;
  localparam logic [7:0] OP_RS_AUX = 8'hE0;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_WR, S_RD, S_DEAD} state_t;

  state_t              state;
  logic                mode_en;
  logic                sclk_q, sen_q;
  logic [CW-1:0]       cnt;
  logic [6:0]          ctrl_sr;
  logic [CMD_BITS-1:0] cmd_sr, cmd_ord;
  logic [RSP_BITS-1:0] rsp_sr, rsp_full, rsp_one;
  logic                use_aux, out_bit;

  wire       rise      = sclk & ~sclk_q;
  wire       fall      = ~sclk & sclk_q;
  wire [7:0] ctrl_byte = {ctrl_sr, sdi};

  always_comb begin
    for (int k = 0; k < RSP_BYTES; k++)
      rsp_full[RSP_BITS-1-8*k -: 8] = rsp_in[8*k +: 8];
    for (int k = 0; k < CMD_BYTES; k++)
      cmd_ord[8*k +: 8] = cmd_sr[CMD_BITS-1-8*k -: 8];
    rsp_one = {rsp_in[7:0], {(RSP_BITS-8){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_en   <= strap_a & strap_b;
      state     <= S_IDLE;
      sclk_q    <= 1'b1;
      sen_q     <= 1'b1;
      cnt       <= '0;
      ctrl_sr   <= '0;
      cmd_sr    <= '0;
      rsp_sr    <= '0;
      use_aux   <= 1'b0;
      out_bit   <= 1'b0;
      cmd_data  <= '0;
      cmd_valid <= 1'b0;
    end else begin
      sclk_q    <= sclk;
      sen_q     <= sen_n;
      cmd_valid <= 1'b0;
      if (sen_n) begin
        if (state == S_WR && cnt == CW'(CMD_BITS)) begin
          cmd_valid <= 1'b1;
          cmd_data  <= cmd_ord;
        end
        state   <= S_IDLE;
        out_bit <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (mode_en) begin
            state <= S_CTRL;
            cnt   <= '0;
          end
          S_CTRL: if (rise) begin
            ctrl_sr <= ctrl_byte[6:0];
            cnt     <= cnt + 1'b1;
            if (cnt == CW'(7)) begin
              cnt <= '0;
              case (ctrl_byte)
                OP_WRITE:  state <= S_WR;
                OP_ST_DIO: begin state <= S_RD; rsp_sr <= rsp_one;  use_aux <= 1'b0; end
                OP_RS_DIO: begin state <= S_RD; rsp_sr <= rsp_full; use_aux <= 1'b0; end
                OP_ST_AUX: begin state <= S_RD; rsp_sr <= rsp_one;  use_aux <= 1'b1; end
                OP_RS_AUX: begin state <= S_RD; rsp_sr <= rsp_full; use_aux <= 1'b1; end
                default:   state <= S_DEAD;
              endcase
            end
          end
          S_WR: if (rise && cnt != CW'(CMD_BITS + 1)) begin
            cnt <= cnt + 1'b1;
            if (cnt < CW'(CMD_BITS)) cmd_sr <= {cmd_sr[CMD_BITS-2:0], sdi};
          end
          S_RD: if (fall) begin
            out_bit <= rsp_sr[RSP_BITS-1];
            rsp_sr  <= {rsp_sr[RSP_BITS-2:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo    = out_bit;
  assign aux_do = out_bit;
  assign sdo_oe = (state == S_RD) & ~use_aux & ~sen_n;
  assign aux_oe = (state == S_RD) &  use_aux & ~sen_n;
endmodule

// File: rtl/ctlbyte_spi_slave_chk.sv
module ctlbyte_spi_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_en,
  input logic sclk,
  input logic sen_n,
  input logic sdo,
  input logic sdo_oe,
  input logic aux_do,
  input logic aux_oe,
  input logic cmd_valid
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe && aux_oe)); // R10

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sen_n) |=> (!sdo_oe && !aux_oe)); // R10

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R2

  AST_STROBE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(sen_n) && !$past(sen_n, 2))); // R2

  AST_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> (!sdo_oe && !aux_oe && !cmd_valid)); // R1

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> (!$past(sclk) && $past(sclk, 2))); // R3

  AST_AUX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_oe && $past(aux_oe) && !$stable(aux_do)) |-> (!$past(sclk) && $past(sclk, 2))); // R5
endmodule

bind ctlbyte_spi_slave ctlbyte_spi_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .sclk(sclk), .sen_n(sen_n),
  .sdo(sdo), .sdo_oe(sdo_oe), .aux_do(aux_do), .aux_oe(aux_oe), .cmd_valid(cmd_valid)
);

// File: tb/ctlbyte_spi_slave_bench.sv
module ctlbyte_spi_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_a = 1'b1, strap_b = 1'b1;
  logic sclk = 1'b1, sen_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, aux_do, aux_oe, cmd_valid;
  logic [127:0] rsp_in;
  logic [63:0]  cmd_data;
  int n_chk = 0, n_bad = 0;
  logic s_sdo, s_aux, s_soe, s_aoe;

  always #2 clk = ~clk;

  ctlbyte_spi_slave u_ctlbyte_spi_slave (
    .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
    .sclk(sclk), .sen_n(sen_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .aux_do(aux_do), .aux_oe(aux_oe), .rsp_in(rsp_in),
    .cmd_data(cmd_data), .cmd_valid(cmd_valid)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic a, input logic b);
    @(negedge clk);
    rst_n = 1'b0; strap_a = a; strap_b = b; sen_n = 1'b1; sclk = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bit_x(input logic b);
    sclk = 1'b0; sdi = b;
    repeat (4) @(negedge clk);
    s_sdo = sdo; s_aux = aux_do; s_soe = sdo_oe; s_aoe = aux_oe;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_x(v[i]);
  endtask

  task automatic start_frame();
    @(negedge clk); sen_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // closes the frame; returns strobe seen one cycle later, next cycle, and oe
  task automatic end_frame(output logic v1, output logic v2, output logic oe1);
    sen_n = 1'b1;
    @(negedge clk); v1 = cmd_valid; oe1 = sdo_oe | aux_oe;
    @(negedge clk); v2 = cmd_valid;
    sclk = 1'b0; repeat (2) @(negedge clk);
    sclk = 1'b1; repeat (2) @(negedge clk);
  endtask

  // sel: 0 shared line, 1 aux pin, 2 neither pin may drive
  task automatic rd_frame(input logic [7:0] ctrl, input int nbytes, input int sel,
                          output logic [127:0] got, output int bad_oe, output logic rel_oe);
    logic v1, v2;
    got = '0; bad_oe = 0;
    start_frame();
    send_byte(ctrl);
    for (int k = 0; k < nbytes; k++) begin
      for (int i = 7; i >= 0; i--) begin
        bit_x(1'b0);
        got[8*k+i] = (sel == 1) ? s_aux : s_sdo;
        if (s_soe !== (sel == 0) || s_aoe !== (sel == 1)) bad_oe++;
      end
    end
    end_frame(v1, v2, rel_oe);
    if (v1 || v2) bad_oe++;
  endtask

  task automatic wr_frame(input logic [63:0] bytes, input int nbytes, input int extra_bits,
                          output logic v1, output logic v2);
    logic oe1;
    start_frame();
    send_byte(8'h48);
    for (int k = 0; k < nbytes; k++) send_byte((k < 8) ? bytes[8*k +: 8] : 8'h77);
    for (int i = 0; i < extra_bits; i++) bit_x(1'b1);
    end_frame(v1, v2, oe1);
  endtask

  task automatic t_reset();
    check("R11 sdo_oe after reset", sdo_oe, 0);
    check("R11 aux_oe after reset", aux_oe, 0);
    check("R11 cmd_valid after reset", cmd_valid, 0);
  endtask

  task automatic t_no_mode();
    logic v1, v2, rel; logic [127:0] got; int bad;
    do_reset(1'b1, 1'b0);
    wr_frame(64'h0123456789ABCDEF, 8, 0, v1, v2);
    check("R1 no strobe when strap low", {v1, v2}, 0);
    rd_frame(8'h80, 1, 2, got, bad, rel);
    check("R1 no drive when strap low", bad, 0);
    check("R1 cmd_data untouched", cmd_data, 0);
    do_reset(1'b1, 1'b1);
  endtask

  task automatic t_write(input logic [63:0] pat);
    logic v1, v2;
    wr_frame(pat, 8, 0, v1, v2);
    check("R2 strobe after close", v1, 1);
    check("R2 strobe one cycle", v2, 0);
    check("R2 command bytes", cmd_data, pat);
  endtask

  task automatic t_bad_len(input string tag, input int nb, input int bits, input logic [63:0] held);
    logic v1, v2;
    wr_frame(64'hFFEEDDCCBBAA9988, nb, bits, v1, v2);
    check({tag, " no strobe"}, {v1, v2}, 0);
    check({tag, " command held"}, cmd_data, held);
  endtask

  task automatic t_read(input string tag, input logic [7:0] ctrl, input int nb,
                        input int sel, input logic [127:0] exp);
    logic [127:0] got; int bad; logic rel;
    rd_frame(ctrl, nb, sel, got, bad, rel);
    check({tag, " data"}, got, exp);
    check({tag, " pin enables"}, bad, 0);
    check("R10 release after close", rel, 0);
  endtask

  task automatic t_illegal(input logic [63:0] pat);
    logic [127:0] got; int bad; logic rel;
    rd_frame(8'h55, 2, 2, got, bad, rel);
    check("R9 illegal control drives nothing", bad, 0);
    t_write(pat);
    check("R9 next frame decoded", cmd_data, pat);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) rsp_in[8*k +: 8] = 8'(k * 37 + 3);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_no_mode();
    t_reset();
    t_write(64'h1122334455667788);
    t_write(64'hA55A0FF0C33C9669);
    t_bad_len("R7 short frame", 5, 0, 64'hA55A0FF0C33C9669);
    t_bad_len("R7 cut mid byte", 3, 4, 64'hA55A0FF0C33C9669);
    t_bad_len("R8 long frame", 9, 0, 64'hA55A0FF0C33C9669);
    t_read("R3 status on shared line", 8'h80, 2, 0, {112'h0, 8'h00, rsp_in[7:0]});
    t_read("R4 response on shared line", 8'hC0, 16, 0, rsp_in);
    t_read("R5 status on aux pin", 8'hA0, 1, 1, {120'h0, rsp_in[7:0]});
    t_read("R6 response on aux pin", 8'hE0, 16, 1, rsp_in);
    t_illegal(64'h0F1E2D3C4B5A6978);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule